// File: doc/BRIEF.md
# Serial EEPROM Erase and Ready/Busy Engine

This block is the device-side command logic of a small serial nonvolatile memory model with a three-wire select/clock/data interface. It brings the select, serial clock and data inputs into the system clock domain and looks for a start bit. It then shifts in a two-bit opcode and an address field. Two commands act on the array: a single-word erase and a whole-array erase. Each sets the target to all ones through a self-timed internal cycle. Any other opcode is shifted in and discarded.

While a cycle runs, and after it ends, the host can poll progress on the serial data output. It holds select low for a minimum number of system clocks and then raises it again. The output then drives 0 while the cycle is in progress and 1 once it has finished. The ready indication stays up across further polls. It is removed only when a new start bit is sent and select is then dropped. At all other times the output is released, which is shown by a separate output-enable signal. An observation port exposes the array contents.

Top module: `mw_erase_engine`

## Requirements
- R1: After reset every array word reads 0, no cycle is running and `do_oe_o` is 0.
- R2: A command begins with the first serial clock rising edge that samples DI=1 while select is high. Rising edges that sample DI=0 before that edge are ignored.
- R3: Opcode bits 1,1 after the start bit, followed by 10 address bits sent most significant bit first, set the addressed word to all ones (0xFF). All other words keep their value.
- R4: Opcode bits 0,0 followed by address bits whose first two are 1,0 set every word to 0xFF. The remaining 8 address bits are don't-care.
- R5: The internal cycle starts on the serial clock edge that captures the final address bit and needs no further serial clocks. It lasts ERASE_CYC system clocks for a single word and ERAL_CYC for the whole array. The array changes when the cycle completes.
- R6: After select has been low for at least TCSL_CYC system clocks and then rises, `do_oe_o` becomes 1 and `do_o` shows 0 while the cycle runs and 1 once it has finished.
- R7: A select low pulse shorter than TCSL_CYC system clocks does not enable the status output.
- R8: `do_oe_o` is 0 whenever select is low, and whenever no status is being shown.
- R9: Once the cycle has finished, the ready indication persists across further qualifying select pulses. It clears only when a start bit is received and select then falls, after which `do_oe_o` stays 0 on later pulses.
- R10: The opcodes 0,1 and 1,0, and opcode 0,0 with an address prefix other than 1,0, change no word and start no cycle.
- R11: Select falling before all 12 bits after the start bit have arrived aborts the command without any effect.
- R12: Start bits that arrive while a cycle is running are ignored, so a command sent during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| do_o | output | 1 | Serial data out value (1 ready, 0 busy) |
| do_oe_o | output | 1 | Output enable for `do_o`; 0 means high-impedance |
| obs_addr_i | input | ADDR_W | Array observation address |
| obs_data_o | output | DATA_W | Array word at `obs_addr_i` |

## Verification
Some behaviours are checked by assertions on every cycle. A cycle never launches while another is running. The array write strobe comes only at the end of a busy period, and a busy period loads one of the two durations. A command in progress returns to idle when select drops. The status output turns on only after a select rising edge and turns off only after a select falling edge while idle. Other behaviours need the bench's scenarios. These are the exact word or words that become 0xFF, the choice of duration, and the short-pulse rule. They also include the persistence of the ready flag across polls, and that ignored, aborted and overlapping commands leave the array and status untouched.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  typedef enum logic {
    ST_IDLE,
    ST_SHIFT
  } mw_state_e;

  localparam logic [1:0] EXT_ALL_PREFIX = 2'b10;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift
  import mw_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rise_i,
  input  logic              di_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              go_o,
  output logic              go_all_o,
  output logic [ADDR_W-1:0] go_addr_o
);
  localparam int unsigned CMD_W = 2 + ADDR_W;
  localparam int unsigned CNT_W = $clog2(CMD_W + 1);

  mw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-2:0] sr_q;
  logic [CMD_W-1:0] word;
  mw_op_e           op;

  assign word = {sr_q, di_i};
  assign op   = mw_op_e'(word[CMD_W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      start_o   <= 1'b0;
      go_o      <= 1'b0;
      go_all_o  <= 1'b0;
      go_addr_o <= '0;
    end else begin
      start_o <= 1'b0;
      go_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cs_i && rise_i && di_i && !busy_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            start_o <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!cs_i) begin
            state_q <= ST_IDLE;
          end else if (rise_i) begin
            sr_q <= word[CMD_W-2:0];
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              state_q <= ST_IDLE;
              if (op == OP_ERASE) begin
                go_o      <= 1'b1;
                go_all_o  <= 1'b0;
                go_addr_o <= word[ADDR_W-1:0];
              end else if (op == OP_EXT && word[ADDR_W-1 -: 2] == EXT_ALL_PREFIX) begin
                go_o      <= 1'b1;
                go_all_o  <= 1'b1;
                go_addr_o <= word[ADDR_W-1:0];
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_ON_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !cs_i) |=> (state_q == ST_IDLE)); // R11
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !busy_i); // R12
endmodule

// File: rtl/mw_erase_timer.sv
module mw_erase_timer #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned ERASE_CYC = 200,
  parameter int unsigned ERAL_CYC  = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              go_all_i,
  input  logic [ADDR_W-1:0] go_addr_i,
  output logic              busy_o,
  output logic              wr_stb_o,
  output logic              wr_all_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int unsigned MAX_CYC = (ERAL_CYC > ERASE_CYC) ? ERAL_CYC : ERASE_CYC;
  localparam int unsigned DUR_W   = $clog2(MAX_CYC + 1);

  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      busy_o    <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_all_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (go_i && !busy_o) begin
        busy_o    <= 1'b1;
        cnt_q     <= go_all_i ? DUR_W'(ERAL_CYC - 1) : DUR_W'(ERASE_CYC - 1);
        wr_all_o  <= go_all_i;
        wr_addr_o <= go_addr_i;
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o   <= 1'b0;
          wr_stb_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_WR_AT_CYCLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (!busy_o && $past(busy_o))); // R5
  AST_DURATION_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cnt_q == DUR_W'(ERASE_CYC - 1) || cnt_q == DUR_W'(ERAL_CYC - 1))); // R5
endmodule

// File: rtl/mw_status.sv
module mw_status #(
  parameter int unsigned TCSL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic busy_i,
  input  logic go_i,
  input  logic start_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int unsigned LC_W = $clog2(TCSL_CYC + 1);

  logic            cs_q, cs_rise, cs_fall;
  logic [LC_W-1:0] low_cnt_q;
  logic            armed_q, show_q, clr_pend_q;

  assign cs_rise = cs_i & ~cs_q;
  assign cs_fall = ~cs_i & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b0;
      low_cnt_q  <= '0;
      armed_q    <= 1'b0;
      show_q     <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
      if (cs_i)                               low_cnt_q <= '0;
      else if (low_cnt_q != LC_W'(TCSL_CYC))  low_cnt_q <= low_cnt_q + 1'b1;

      if (cs_fall && clr_pend_q) begin
        show_q     <= 1'b0;
        armed_q    <= 1'b0;
        clr_pend_q <= 1'b0;
      end else begin
        if (go_i) begin
          armed_q    <= 1'b1;
          clr_pend_q <= 1'b0;
        end else if (start_i && show_q && !busy_i) begin
          clr_pend_q <= 1'b1;
        end
        if (cs_rise && armed_q && low_cnt_q >= LC_W'(TCSL_CYC)) show_q <= 1'b1;
      end
    end
  end

  assign do_oe_o = show_q & cs_i;
  assign do_o    = ~busy_i;

  AST_SHOW_AFTER_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(show_q) |-> $past(cs_rise)); // R6
  AST_CLEAR_ON_CS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(show_q) |-> ($past(cs_fall) && !busy_i)); // R9
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              wr_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[i] <= '0;
      else if (wr_stb_i && (wr_all_i || wr_addr_i == ADDR_W'(i)))
        mem_q[i] <= '1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mw_erase_engine.sv
module mw_erase_engine #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ERASE_CYC   = 200,
  parameter int unsigned ERAL_CYC    = 600,
  parameter int unsigned TCSL_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic [DATA_W-1:0] obs_data_o
);
  logic              cs_s, sclk_s, di_s, sclk_q, rise;
  logic              start, go, go_all, busy, wr_stb, wr_all;
  logic [ADDR_W-1:0] go_addr, wr_addr;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sclk_i, di_i}),
    .q_o   ({cs_s, sclk_s, di_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end
  assign rise = sclk_s & ~sclk_q;

  mw_cmd_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_s),
    .rise_i   (rise),
    .di_i     (di_s),
    .busy_i   (busy),
    .start_o  (start),
    .go_o     (go),
    .go_all_o (go_all),
    .go_addr_o(go_addr)
  );

  mw_erase_timer #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .ERAL_CYC(ERAL_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .go_all_i (go_all),
    .go_addr_i(go_addr),
    .busy_o   (busy),
    .wr_stb_o (wr_stb),
    .wr_all_o (wr_all),
    .wr_addr_o(wr_addr)
  );

  mw_status #(.TCSL_CYC(TCSL_CYC)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_s),
    .busy_i (busy),
    .go_i   (go),
    .start_i(start),
    .do_o   (do_o),
    .do_oe_o(do_oe_o)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .wr_all_i (wr_all),
    .wr_addr_i(wr_addr),
    .rd_addr_i(obs_addr_i),
    .rd_data_o(obs_data_o)
  );

  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !$past(cs_s)) |-> !do_oe_o); // R8
endmodule

// File: tb/mw_erase_engine_tb.sv
`timescale 1ns/1ps
module mw_erase_engine_tb;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int ERASE_CYC = 200;
  localparam int ERAL_CYC = 600;
  localparam int TCSL_CYC = 4;

  logic clk = 1'b0, rst_ni = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_v, do_oe;
  logic [AW-1:0] obs_addr = '0;
  logic [DW-1:0] obs_data;
  logic [DW-1:0] mdl [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mw_erase_engine #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(ERASE_CYC),
                    .ERAL_CYC(ERAL_CYC), .TCSL_CYC(TCSL_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .do_o(do_v), .do_oe_o(do_oe), .obs_addr_i(obs_addr), .obs_data_o(obs_data)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_erase(input logic [1:0] op);
    return op == 2'b11;
  endfunction

  function automatic bit is_eral(input logic [1:0] op, input logic [AW-1:0] a);
    return op == 2'b00 && a[AW-1 -: 2] == 2'b10;
  endfunction

  function automatic void apply_model(input logic [1:0] op, input logic [AW-1:0] a);
    if (is_erase(op)) mdl[a] = '1;
    else if (is_eral(op, a)) for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
  endfunction

  task automatic clk_bit(input logic b);
    di = b; tick(3);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(3);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
    di = 1'b0;
  endtask

  task automatic cs_pulse(input int low_len);
    cs = 1'b0; tick(low_len);
    cs = 1'b1; tick(5);
  endtask

  task automatic clear_status();
    clk_bit(1'b1);
    cs = 1'b0; tick(4);
    cs = 1'b1; tick(5);
  endtask

  task automatic scan(input string tag);
    int mism = 0, first = -1;
    for (int a = 0; a < DEPTH; a++) begin
      obs_addr = AW'(a); #1;
      if (obs_data !== mdl[a]) begin
        mism++;
        if (first < 0) first = a;
      end
    end
    chk(mism == 0, tag, first < 0 ? 0 : int'(obs_data_at(first)), first < 0 ? 0 : int'(mdl[first]));
  endtask

  function automatic logic [DW-1:0] obs_data_at(input int a);
    return u_dut.u_array.mem_q[a];
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; cs = 1'b0; sclk = 1'b0; di = 1'b0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    tick(3);
    rst_ni = 1'b1; tick(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", 0, 1);
    finish_run();
  end

  initial begin
    logic [AW-1:0] a, b;
    logic [1:0] op;
    void'($urandom(32'h5eed_0042));
    do_reset();
    chk(do_oe == 1'b0, "R1 oe after reset", do_oe, 0);
    scan("R1 array zero after reset");

    // leading zeros, then ERASE of top word
    cs = 1'b1; tick(5);
    clk_bit(1'b0); clk_bit(1'b0);
    send_cmd(2'b11, 10'h3FF);
    cs_pulse(8);
    chk(do_oe == 1'b1, "R6 oe busy poll", do_oe, 1);
    chk(do_v == 1'b0, "R6 busy shows 0", do_v, 0);
    obs_addr = 10'h3FF; #1;
    chk(obs_data == 8'h00, "R5 word unchanged during cycle", obs_data, 0);
    tick(ERASE_CYC + 20);
    chk(do_oe == 1'b1 && do_v == 1'b1, "R5 ready without more CLK", {do_oe, do_v}, 3);
    apply_model(2'b11, 10'h3FF);
    scan("R2 R3 single word erased");

    // persistence and clearing
    cs_pulse(8);
    chk(do_oe == 1'b1 && do_v == 1'b1, "R9 ready persists", {do_oe, do_v}, 3);
    cs = 1'b0; tick(4);
    chk(do_oe == 1'b0, "R8 oe low with cs low", do_oe, 0);
    cs = 1'b1; tick(5);
    clear_status();
    cs_pulse(8);
    chk(do_oe == 1'b0, "R9 status cleared", do_oe, 0);

    // short pulse
    a = AW'($urandom);
    send_cmd(2'b11, a);
    cs = 1'b0; tick(2); cs = 1'b1; tick(5);
    chk(do_oe == 1'b0, "R7 short pulse no status", do_oe, 0);
    tick(ERASE_CYC + 20);
    cs_pulse(TCSL_CYC + 2);
    chk(do_oe == 1'b1 && do_v == 1'b1, "R6 ready after qualified pulse", {do_oe, do_v}, 3);
    apply_model(2'b11, a);
    scan("R3 random word erased");
    clear_status();

    // command while busy
    a = AW'($urandom); b = a ^ 10'h001;
    send_cmd(2'b11, a);
    cs_pulse(8);
    send_cmd(2'b11, b);
    tick(ERASE_CYC + 20);
    chk(do_oe == 1'b1 && do_v == 1'b1, "R12 first cycle done", {do_oe, do_v}, 3);
    apply_model(2'b11, a);
    scan("R12 command during busy ignored");
    clear_status();

    // ignored opcodes
    send_cmd(2'b01, 10'h155); cs_pulse(8);
    chk(do_oe == 1'b0, "R10 opcode 01 no status", do_oe, 0);
    send_cmd(2'b10, 10'h2AA); cs_pulse(8);
    chk(do_oe == 1'b0, "R10 opcode 10 no status", do_oe, 0);
    send_cmd(2'b00, 10'h3C3); cs_pulse(8);
    send_cmd(2'b00, 10'h0FF); cs_pulse(8);
    send_cmd(2'b00, 10'h1AA); cs_pulse(8);
    chk(do_oe == 1'b0, "R10 ext prefix not 10 no status", do_oe, 0);
    tick(ERAL_CYC);
    scan("R10 ignored opcodes leave array");

    // abort
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
    for (int i = 0; i < 5; i++) clk_bit(1'b0);
    cs = 1'b0; tick(6); cs = 1'b1; tick(5);
    for (int i = 0; i < 5; i++) clk_bit(1'b0);
    tick(ERASE_CYC + 20);
    cs_pulse(8);
    chk(do_oe == 1'b0, "R11 aborted no status", do_oe, 0);
    scan("R11 aborted array unchanged");

    // ERAL
    a = {2'b10, 8'($urandom)};
    send_cmd(2'b00, a);
    cs_pulse(8);
    tick(ERASE_CYC + 40);
    chk(do_oe == 1'b1 && do_v == 1'b0, "R5 whole-array still busy", {do_oe, do_v}, 2);
    tick(ERAL_CYC);
    chk(do_oe == 1'b1 && do_v == 1'b1, "R5 whole-array ready", {do_oe, do_v}, 3);
    apply_model(2'b00, a);
    scan("R4 all words erased");
    clear_status();

    // random phase
    do_reset();
    chk(do_oe == 1'b0, "R1 oe after second reset", do_oe, 0);
    cs = 1'b1; tick(5);
    for (int k = 0; k < 10; k++) begin
      op = 2'($urandom);
      a = AW'($urandom);
      if (k % 3 == 0) op = 2'b11;
      send_cmd(op, a);
      tick(ERAL_CYC + 20);
      cs_pulse(8);
      apply_model(op, a);
      if (is_erase(op) || is_eral(op, a)) begin
        chk(do_oe == 1'b1 && do_v == 1'b1, "R6 random ready", {do_oe, do_v}, 3);
        clear_status();
        cs_pulse(8);
        chk(do_oe == 1'b0, "R9 random clear", do_oe, 0);
      end else begin
        chk(do_oe == 1'b0, "R10 random ignored", do_oe, 0);
      end
    end
    scan("R3 R4 random array");
    finish_run();
  end
endmodule